// File: doc/BRIEF.md
# Four-Channel Stepped-Frequency PWM Generator

This block drives four independent pulse-width-modulated output pins from a single reference tick. Each channel takes a frequency byte, a duty byte, a polarity bit and an enable bit from configuration registers held elsewhere in the chip. The frequency byte selects one of four resolution bands and a count within that band, which together span 0.5 Hz to 2048 Hz when the reference tick runs at 2^20 × 0.5 Hz (524 288 Hz).

Each channel keeps a phase accumulator that advances by a band-scaled step on every reference tick. The top eight bits of the phase give the position within a 256-slot period. The pin is high while that position is at or below the duty value, so the high fraction is (duty+1)/256 and a zero-percent output cannot be produced. Polarity inversion follows the comparison, and the enable gate comes last, so a disabled pin is always low. Frequency, duty and polarity are captured on the next reference tick. The accumulator is never restarted, so the period that spans a change may mix the old and new settings.

Top module: `pwm_stepped_multi`

## Requirements
- R1: Each frequency byte holds the band in bits 7:6 and the count in bits 5:0; the phase step per tick is (count+1) shifted left by 2×band.
- R2: With a power-of-two step, the output period is 2^20 / step reference ticks (band 0, count 63 gives 16384 ticks; band 3, count 63 gives 256 ticks).
- R3: The output is high while the 8-bit slot position (phase bits 19:12) is less than or equal to the duty byte, giving (duty+1)×4096/step high ticks per period.
- R4: A duty byte of 0 still yields a high time of 1/256 of the period, and a duty byte of 255 holds the output high for the whole period.
- R5: When a channel's polarity bit is 1, its output is the complement of the comparison result, so the high time becomes (255-duty)/256 of the period.
- R6: When a channel's enable bit is 0, its output is low from the next clock edge on, regardless of the other settings.
- R7: Frequency, duty and polarity are captured only on a clock edge where the tick input is 1; while tick is 0 the phase and the outputs hold steady.
- R8: Each channel's period and high time depend only on that channel's settings; the four channels run at once with different settings.
- R9: While the active-low reset is asserted, all outputs are low and all phases return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick enable, one clock wide per tick |
| freq_cfg | input | 32 | Four frequency bytes, channel n at bits 8n+7:8n |
| duty_cfg | input | 32 | Four duty bytes, channel n at bits 8n+7:8n |
| pol_cfg | input | 4 | Per-channel polarity invert, bit n for channel n |
| chan_en | input | 4 | Per-channel enable, bit n for channel n |
| pwm_out | output | 4 | Per-channel pin-level output |

## Verification
The four channels are set at once to one setting in each band with duties of 127, 63, 0 and 200, and period and high time are measured in ticks on each pin; this separates band decoding errors (wrong period) from comparison errors (wrong high time) and shows the channels do not interfere. Inverted polarity on the fastest channel tells apart a correct post-compare inversion from an inverted duty. Duty 255 and a cleared enable check the two steady-state ends, and a stalled tick with a changed duty shows that nothing moves until the next tick and that the new duty then applies.

// File: rtl/pwm_step_pkg.sv
// Package: shared field widths and the band-to-step computation.
// Assumes the frequency byte is {band, count} with band in the top bits.
package pwm_step_pkg;
    localparam int BAND_W  = 2;
    localparam int COUNT_W = 6;
    localparam int FREQ_W  = BAND_W + COUNT_W;
    // Largest step is 2^COUNT_W shifted by 2*(2^BAND_W-1)
    localparam int STEP_W  = COUNT_W + 1 + 2 * ((1 << BAND_W) - 1);

    // Phase increment for a frequency byte: (count+1) << (2*band)
    function automatic logic [STEP_W-1:0] step_of(input logic [FREQ_W-1:0] f);
        logic [STEP_W-1:0] base;
        logic [BAND_W-1:0] band;
        base = STEP_W'(f[COUNT_W-1:0]) + STEP_W'(1);
        band = f[FREQ_W-1:COUNT_W];
        return base << (2 * band);
    endfunction
endpackage

// File: rtl/pwm_cfg_hold.sv
// Module: per-channel configuration hold.
// Captures frequency, duty and polarity on a tick and presents the
// step derived from the captured frequency. Assumes tick is one clock wide.
module pwm_cfg_hold
    import pwm_step_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [FREQ_W-1:0]   freq_in,
    input  logic [DUTY_W-1:0]   duty_in,
    input  logic                pol_in,
    output logic [STEP_W-1:0]   step,
    output logic [DUTY_W-1:0]   duty_live,
    output logic                pol_live
);
    logic [FREQ_W-1:0] freq_q;

    // Capture the register values on a reference tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q    <= '0;
            duty_live <= '0;
            pol_live  <= 1'b0;
        end else if (tick) begin
            freq_q    <= freq_in;
            duty_live <= duty_in;
            pol_live  <= pol_in;
        end
    end

    // Derive the phase increment from the held frequency byte
    always_comb begin
        step = step_of(freq_q);
    end
endmodule

// File: rtl/pwm_phase_acc.sv
// Module: phase accumulator.
// Adds the step on every tick and wraps at 2^PHASE_W; never restarts
// except on reset. Assumes PHASE_W >= STEP_W and PHASE_W >= POS_W.
module pwm_phase_acc
    import pwm_step_pkg::*;
#(
    parameter int PHASE_W = 20,
    parameter int POS_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [STEP_W-1:0]  step,
    output logic [POS_W-1:0]   pos
);
    logic [PHASE_W-1:0] phase_q;

    // Advance the phase by the step on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + PHASE_W'(step);
        end
    end

    // Slot position is the top bits of the phase
    always_comb begin
        pos = phase_q[PHASE_W-1 -: POS_W];
    end
endmodule

// File: rtl/pwm_pin_stage.sv
// Module: output pin stage.
// Compares slot position against duty, applies polarity, then the
// enable gate, and registers the result. Assumes equal widths.
module pwm_pin_stage #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] pos,
    input  logic [DUTY_W-1:0] duty,
    input  logic              pol,
    input  logic              en,
    output logic              pin
);
    logic raw_high;

    // Active part of the period: position at or below duty
    always_comb begin
        raw_high = (pos <= duty);
    end

    // Register the gated, polarity-adjusted level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            pin <= en & (raw_high ^ pol);
        end
    end
endmodule

// File: rtl/pwm_stepped_multi.sv
// Module: four-channel stepped-frequency PWM generator (top).
// One hold, accumulator and pin stage per channel. Assumes the tick
// input is a one-clock enable at the reference rate.
module pwm_stepped_multi
    import pwm_step_pkg::*;
#(
    parameter int CH_N    = 4,
    parameter int DUTY_W  = 8,
    parameter int PHASE_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [CH_N*FREQ_W-1:0] freq_cfg,
    input  logic [CH_N*DUTY_W-1:0] duty_cfg,
    input  logic [CH_N-1:0]        pol_cfg,
    input  logic [CH_N-1:0]        chan_en,
    output logic [CH_N-1:0]        pwm_out
);
    logic [CH_N*DUTY_W-1:0] duty_live;
    logic [CH_N*DUTY_W-1:0] slot_pos;
    logic [CH_N-1:0]        pol_live;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic [STEP_W-1:0] step;

        pwm_cfg_hold #(.DUTY_W(DUTY_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .freq_in   (freq_cfg[g*FREQ_W +: FREQ_W]),
            .duty_in   (duty_cfg[g*DUTY_W +: DUTY_W]),
            .pol_in    (pol_cfg[g]),
            .step      (step),
            .duty_live (duty_live[g*DUTY_W +: DUTY_W]),
            .pol_live  (pol_live[g])
        );

        pwm_phase_acc #(.PHASE_W(PHASE_W), .POS_W(DUTY_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .step  (step),
            .pos   (slot_pos[g*DUTY_W +: DUTY_W])
        );

        pwm_pin_stage #(.DUTY_W(DUTY_W)) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pos   (slot_pos[g*DUTY_W +: DUTY_W]),
            .duty  (duty_live[g*DUTY_W +: DUTY_W]),
            .pol   (pol_live[g]),
            .en    (chan_en[g]),
            .pin   (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_stepped_checker.sv
// Module: property checker bound to the top.
// Relates enables, held settings and slot position to the pins.
module pwm_stepped_checker #(
    parameter int CH_N   = 4,
    parameter int DUTY_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input logic [CH_N-1:0]        chan_en,
    input logic [CH_N-1:0]        pwm_out,
    input logic [CH_N*DUTY_W-1:0] duty_live,
    input logic [CH_N-1:0]        pol_live,
    input logic [CH_N*DUTY_W-1:0] slot_pos
);
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pwm_out & ~$past(chan_en)) == '0)); // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(slot_pos) && $stable(duty_live) && $stable(pol_live))); // R7

    for (genvar g = 0; g < CH_N; g++) begin : g_chk
        AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && !pol_live[g] && duty_live[g*DUTY_W +: DUTY_W] == '1)
            |=> pwm_out[g]); // R4

        AST_SLOT_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && !pol_live[g] && slot_pos[g*DUTY_W +: DUTY_W] == '0)
            |=> pwm_out[g]); // R4

        AST_PAST_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!pol_live[g] &&
             slot_pos[g*DUTY_W +: DUTY_W] > duty_live[g*DUTY_W +: DUTY_W])
            |=> !pwm_out[g]); // R3

        AST_INVERT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && pol_live[g] &&
             slot_pos[g*DUTY_W +: DUTY_W] > duty_live[g*DUTY_W +: DUTY_W])
            |=> pwm_out[g]); // R5
    end
endmodule

bind pwm_stepped_multi pwm_stepped_checker #(.CH_N(CH_N), .DUTY_W(DUTY_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .chan_en   (chan_en),
    .pwm_out   (pwm_out),
    .duty_live (duty_live),
    .pol_live  (pol_live),
    .slot_pos  (slot_pos)
);

// File: tb/test_pwm_stepped_multi.sv
// Bench: directed scenarios, one task each; tick runs every clock.
module test_pwm_stepped_multi;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] freq_cfg = '0;
    logic [31:0] duty_cfg = '0;
    logic [3:0]  pol_cfg = '0;
    logic [3:0]  chan_en = '0;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pwm_stepped_multi i_pwm_stepped_multi (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freq_cfg(freq_cfg),
        .duty_cfg(duty_cfg), .pol_cfg(pol_cfg), .chan_en(chan_en),
        .pwm_out(pwm_out)
    );

    // Watchdog: an expired run is a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    // Skip a settling rise, then count period and high ticks
    task automatic measure(input int ch, input int per, input int hi, input string tag);
        int n;
        int h;
        wait_rise(ch);
        wait_rise(ch);
        n = 1;
        h = 1;
        forever begin
            logic prev;
            prev = pwm_out[ch];
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            n = n + 1;
            if (pwm_out[ch]) h = h + 1;
        end
        check({tag, " period"}, n, per);
        check({tag, " high"}, h, hi);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 outputs low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        tick  = 1'b1;
    endtask

    // One setting per band, all channels at once (R1, R2, R3, R4, R8)
    task automatic t_bands();
        freq_cfg = {8'hFF, 8'h8F, 8'h5F, 8'h3F};
        duty_cfg = {8'd200, 8'd0, 8'd63, 8'd127};
        pol_cfg  = 4'b0000;
        chan_en  = 4'b1111;
        measure(0, 16384, 8192, "R1 R2 R3 R8 ch0 band0");
        measure(1, 8192, 2048, "R1 R2 R3 R8 ch1 band1");
        measure(2, 4096, 16, "R4 R2 ch2 duty0");
        measure(3, 256, 201, "R2 R3 ch3 band3");
    endtask

    task automatic t_polarity();
        pol_cfg[3] = 1'b1;
        measure(3, 256, 55, "R5 inverted ch3");
        pol_cfg[3] = 1'b0;
    endtask

    task automatic t_full_duty();
        int lows;
        duty_cfg[31:24] = 8'd255;
        repeat (300) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pwm_out[3]) lows = lows + 1;
        end
        check("R4 duty255 low samples", lows, 0);
    endtask

    task automatic t_disable();
        int highs;
        chan_en[3] = 1'b0;
        @(negedge clk);
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            if (pwm_out[3]) highs = highs + 1;
            @(negedge clk);
        end
        check("R6 disabled high samples", highs, 0);
        chan_en[3] = 1'b1;
    endtask

    task automatic t_stall();
        logic held;
        int   moved;
        duty_cfg[31:24] = 8'd0;
        repeat (600) @(negedge clk);
        wait_rise(3);
        repeat (40) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        held = pwm_out[3];
        duty_cfg[31:24] = 8'd255;
        moved = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out[3] != held) moved = moved + 1;
        end
        check("R7 output held without tick", moved, 0);
        check("R7 held level before tick", int'(held), 0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        check("R7 new duty after tick", int'(pwm_out[3]), 1);
        tick = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bands();
        t_polarity();
        t_full_duty();
        t_disable();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule